// File: doc/BRIEF.md
# Eight-Input Cascadable Interrupt Controller

This block gathers interrupt requests from eight level-sensitive inputs and presents a single interrupt line to a processor. Each input has its own mask bit and in-service bit. Input 0 has the highest priority and input 7 the lowest. A request reaches the processor only when it is unmasked and has a strictly higher priority than everything already in service. The processor acknowledges with two strobes on `inta`. The first strobe picks the winning input and marks it in service. The second strobe releases an 8-bit vector: the upper five bits come from a programmed base and the lower three bits are the input number.

Software talks to the block over a small port. It uses a chip select, write and read strobes, one address bit and an 8-bit data bus. After reset, or whenever a restart word is written, the block expects an ordered sequence of setup words: three words, or four when the controllers are cascaded. Once setup is complete, later writes load the mask, issue end-of-interrupt commands, or choose which register a read returns.

Controllers can be cascaded. A master marks some of its inputs as fed by slaves. When one of those inputs wins, the master does not put out a vector: it places the input number on the 3-bit cascade bus. The slave whose programmed ID matches that number then supplies the vector.

Top module: `pic_core`

## Requirements
- R1: During and after reset, `int_out`, `vec_oe` and `cas_oe` are 0, and the block is not set up.
- R2: A write with `a0`=0 and data bit 4 set is the first setup word. Its bit 0 set means a fourth word follows. The following `a0`=1 writes are taken in order: the base (data bits 7:3), the cascade word, then the optional mode word. No request reaches `int_out` until the last setup word is written.
- R3: After setup, an `a0`=1 write loads the mask, and a read with `a0`=1 returns it. A set mask bit keeps its input from raising `int_out`.
- R4: `int_out` is 1 two clock edges after an input rises, when that input is unmasked and its index is lower than the index of every set in-service bit. An input that is in service, or that is below one in service, does not raise `int_out`.
- R5: The first `inta` strobe sets the in-service bit of the winning input. The second strobe makes `vec_oe` 1 for exactly one cycle, with `vec_out` = {base[7:3], input index}.
- R6: A write with `a0`=0 and data 0x20 clears the lowest-index set in-service bit. Data 0x60|n clears in-service bit n.
- R7: A write with `a0`=0 and data 0x0B selects the in-service register for `a0`=0 reads. Data 0x0A selects the raw request register. The request register is selected after reset and after a restart word. Read data appears one cycle after the read strobe.
- R8: A master (four setup words, mode word bit 2 = 1) treats the set bits of the cascade word as slave-fed inputs. When such an input wins, `cas_oe`=1 and `cas_out` = its index, from the cycle after the first strobe through the cycle of the second strobe. `vec_oe` stays 0 for that acknowledge.
- R9: A slave (four setup words, mode word bit 2 = 0) takes its ID from cascade word bits 2:0. At the second strobe it supplies its vector and sets its in-service bit only if `cas_in` equals its ID. Otherwise it does neither.
- R10: If the first strobe finds no request to forward, the in-service register stays unchanged and the vector is {base, 7}.
- R11: A restart word written during operation clears the mask and the in-service bits, and holds `int_out` at 0 until setup completes again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select for the register port |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| a0 | input | 1 | Register address bit |
| din | input | 8 | Write data |
| dout | output | 8 | Registered read data |
| irq_in | input | 8 | Level-sensitive interrupt requests |
| int_out | output | 1 | Interrupt request to the processor |
| inta | input | 1 | Acknowledge strobe, one cycle per pulse |
| vec_out | output | 8 | Vector released on the second strobe |
| vec_oe | output | 1 | Vector valid |
| cas_in | input | 3 | Cascade ID observed (slave role) |
| cas_out | output | 3 | Cascade ID driven (master role) |
| cas_oe | output | 1 | Cascade ID valid |

## Verification
The bench builds the block with its default of eight inputs. This gives a 3-bit input index and a 5-bit base field, so every vector code, every priority level and every cascade ID value can be reached. One instance is set up again and again, first as a standalone controller, then as a master with a slave on input 3, then as a slave with ID 5. This covers both cascade roles and the restart path. The random rounds pair request and mask patterns, and each acknowledged vector is compared against the lowest unmasked index.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [2:0] {
    ST_UNINIT,
    ST_WAIT_BASE,
    ST_WAIT_CASC,
    ST_WAIT_MODE,
    ST_READY
  } setup_st_t;

  localparam logic [2:0] CMD_EOI_ANY = 3'b001;
  localparam logic [2:0] CMD_EOI_LVL = 3'b011;
endpackage

// File: rtl/pic_prio.sv
module pic_prio #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx = IW'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pic_regif.sv
module pic_regif
  import pic_pkg::*;
#(
  parameter int N_IN   = 8,
  parameter int ID_W   = $clog2(N_IN),
  parameter int BASE_W = N_IN - ID_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              wr,
  input  logic              rd,
  input  logic              a0,
  input  logic [N_IN-1:0]   din,
  input  logic [N_IN-1:0]   irr,
  input  logic [N_IN-1:0]   isr,
  output logic [N_IN-1:0]   dout,
  output logic [N_IN-1:0]   mask,
  output logic [BASE_W-1:0] base,
  output logic              ready,
  output logic              is_slave,
  output logic [N_IN-1:0]   slave_map,
  output logic [ID_W-1:0]   own_id,
  output logic              eoi_any,
  output logic              eoi_lvl,
  output logic [ID_W-1:0]   eoi_num,
  output logic              restart
);
  setup_st_t         st;
  logic              need_mode;
  logic              mode_master;
  logic              rd_isr;
  logic [N_IN-1:0]   casc_word;
  logic              wr_en;
  logic              cmd_wr;

  assign wr_en   = cs & wr;
  assign restart = wr_en & ~a0 & din[4];
  assign ready   = (st == ST_READY);
  assign cmd_wr  = wr_en & ~a0 & ~din[4] & ready;
  assign eoi_any = cmd_wr & ~din[3] & (din[7:5] == CMD_EOI_ANY);
  assign eoi_lvl = cmd_wr & ~din[3] & (din[7:5] == CMD_EOI_LVL);
  assign eoi_num = din[ID_W-1:0];

  assign is_slave  = need_mode & ~mode_master;
  assign slave_map = (need_mode & mode_master) ? casc_word : '0;
  assign own_id    = casc_word[ID_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_UNINIT;
      need_mode   <= 1'b0;
      mode_master <= 1'b1;
      rd_isr      <= 1'b0;
      casc_word   <= '0;
      mask        <= '0;
      base        <= '0;
      dout        <= '0;
    end else begin
      if (restart) begin
        st          <= ST_WAIT_BASE;
        need_mode   <= din[0];
        mode_master <= 1'b1;
        rd_isr      <= 1'b0;
        mask        <= '0;
      end else if (wr_en & a0) begin
        case (st)
          ST_WAIT_BASE: begin
            base <= din[N_IN-1 -: BASE_W];
            st   <= ST_WAIT_CASC;
          end
          ST_WAIT_CASC: begin
            casc_word <= din;
            st        <= need_mode ? ST_WAIT_MODE : ST_READY;
          end
          ST_WAIT_MODE: begin
            mode_master <= din[2];
            st          <= ST_READY;
          end
          ST_READY: mask <= din;
          default: ;
        endcase
      end else if (cmd_wr & din[3] & din[1]) begin
        rd_isr <= din[0];
      end
      if (cs & rd)
        dout <= a0 ? mask : (rd_isr ? isr : irr);
    end
  end
endmodule

// File: rtl/pic_ack.sv
module pic_ack #(
  parameter int N_IN   = 8,
  parameter int ID_W   = $clog2(N_IN),
  parameter int BASE_W = N_IN - ID_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inta,
  input  logic              ready,
  input  logic [N_IN-1:0]   irr,
  input  logic [N_IN-1:0]   mask,
  input  logic [BASE_W-1:0] base,
  input  logic [N_IN-1:0]   slave_map,
  input  logic              is_slave,
  input  logic [ID_W-1:0]   own_id,
  input  logic [ID_W-1:0]   cas_in,
  input  logic              eoi_any,
  input  logic              eoi_lvl,
  input  logic [ID_W-1:0]   eoi_num,
  input  logic              restart,
  output logic [N_IN-1:0]   isr,
  output logic              int_out,
  output logic [N_IN-1:0]   vec_out,
  output logic              vec_oe,
  output logic [ID_W-1:0]   cas_out,
  output logic              cas_oe
);
  logic [ID_W-1:0] p_idx, s_idx, sel;
  logic            p_any, s_any, fwd, phase, sel_ok;
  logic [N_IN-1:0] pending, isr_kept, isr_nxt, eoi_clr;
  logic            pulse1, pulse2, slave_hit;

  assign pending = irr & ~mask;

  pic_prio #(.N(N_IN), .IW(ID_W)) u_pend_prio (.req(pending), .idx(p_idx), .any(p_any));
  pic_prio #(.N(N_IN), .IW(ID_W)) u_svc_prio  (.req(isr),     .idx(s_idx), .any(s_any));

  assign fwd       = ready & p_any & (~s_any | (p_idx < s_idx));
  assign pulse1    = inta & ready & ~phase;
  assign pulse2    = inta & ready & phase;
  assign slave_hit = is_slave & sel_ok & (cas_in == own_id);

  always_comb begin
    eoi_clr = '0;
    if (eoi_any & s_any) eoi_clr = N_IN'(1) << s_idx;
    else if (eoi_lvl)    eoi_clr = N_IN'(1) << eoi_num;
    isr_kept = isr & ~eoi_clr;
    isr_nxt  = isr_kept;
    if (restart)
      isr_nxt = '0;
    else if (pulse1 & fwd & ~is_slave)
      isr_nxt = isr_kept | (N_IN'(1) << p_idx);
    else if (pulse2 & slave_hit)
      isr_nxt = isr_kept | (N_IN'(1) << sel);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      isr     <= '0;
      int_out <= 1'b0;
      phase   <= 1'b0;
      sel     <= '0;
      sel_ok  <= 1'b0;
      vec_out <= '0;
      vec_oe  <= 1'b0;
      cas_out <= '0;
      cas_oe  <= 1'b0;
    end else begin
      isr     <= isr_nxt;
      int_out <= fwd;
      vec_oe  <= 1'b0;
      if (restart) begin
        phase  <= 1'b0;
        cas_oe <= 1'b0;
      end else if (pulse1) begin
        phase  <= 1'b1;
        sel    <= fwd ? p_idx : '1;
        sel_ok <= fwd;
        if (fwd & ~is_slave & slave_map[p_idx]) begin
          cas_out <= p_idx;
          cas_oe  <= 1'b1;
        end
      end else if (pulse2) begin
        phase  <= 1'b0;
        cas_oe <= 1'b0;
        if (is_slave) begin
          if (slave_hit) begin
            vec_oe  <= 1'b1;
            vec_out <= {base, sel};
          end
        end else if (!(sel_ok & slave_map[sel])) begin
          vec_oe  <= 1'b1;
          vec_out <= {base, sel};
        end
      end
    end
  end
endmodule

// File: rtl/pic_core.sv
module pic_core #(
  parameter int N_IN = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cs,
  input  logic                     wr,
  input  logic                     rd,
  input  logic                     a0,
  input  logic [N_IN-1:0]          din,
  output logic [N_IN-1:0]          dout,
  input  logic [N_IN-1:0]          irq_in,
  output logic                     int_out,
  input  logic                     inta,
  output logic [N_IN-1:0]          vec_out,
  output logic                     vec_oe,
  input  logic [$clog2(N_IN)-1:0]  cas_in,
  output logic [$clog2(N_IN)-1:0]  cas_out,
  output logic                     cas_oe
);
  localparam int ID_W   = $clog2(N_IN);
  localparam int BASE_W = N_IN - ID_W;

  logic [N_IN-1:0]   irr, isr, mask, slave_map;
  logic [BASE_W-1:0] base;
  logic [ID_W-1:0]   own_id, eoi_num;
  logic              cfg_ready, is_slave, eoi_any, eoi_lvl, restart;

  always_ff @(posedge clk) begin
    if (rst) irr <= '0;
    else     irr <= irq_in;
  end

  pic_regif #(.N_IN(N_IN), .ID_W(ID_W), .BASE_W(BASE_W)) u_regif (
    .clk(clk), .rst(rst), .cs(cs), .wr(wr), .rd(rd), .a0(a0), .din(din),
    .irr(irr), .isr(isr), .dout(dout), .mask(mask), .base(base),
    .ready(cfg_ready), .is_slave(is_slave), .slave_map(slave_map),
    .own_id(own_id), .eoi_any(eoi_any), .eoi_lvl(eoi_lvl),
    .eoi_num(eoi_num), .restart(restart)
  );

  pic_ack #(.N_IN(N_IN), .ID_W(ID_W), .BASE_W(BASE_W)) u_ack (
    .clk(clk), .rst(rst), .inta(inta), .ready(cfg_ready), .irr(irr),
    .mask(mask), .base(base), .slave_map(slave_map), .is_slave(is_slave),
    .own_id(own_id), .cas_in(cas_in), .eoi_any(eoi_any), .eoi_lvl(eoi_lvl),
    .eoi_num(eoi_num), .restart(restart), .isr(isr), .int_out(int_out),
    .vec_out(vec_out), .vec_oe(vec_oe), .cas_out(cas_out), .cas_oe(cas_oe)
  );
endmodule

// File: rtl/pic_core_chk.sv
module pic_core_chk #(
  parameter int N_IN = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            int_out,
  input logic            vec_oe,
  input logic            cas_oe,
  input logic            inta,
  input logic            cfg_ready,
  input logic            is_slave,
  input logic [N_IN-1:0] isr
);
  AST_NO_INT_UNSET: assert property (@(posedge clk) disable iff (rst)
    !cfg_ready |=> !int_out); // R2

  AST_VEC_CAS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(vec_oe && cas_oe)); // R8

  AST_VEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    vec_oe |=> !vec_oe); // R5

  AST_VEC_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    vec_oe |-> $past(inta)); // R5

  AST_ISR_SET_ON_ACK: assert property (@(posedge clk) disable iff (rst)
    ($countones(isr & ~$past(isr)) != 0) |-> $past(inta)); // R5

  AST_CAS_MASTER_ONLY: assert property (@(posedge clk) disable iff (rst)
    cas_oe |-> !is_slave); // R8

  AST_ISR_ONE_PER_ACK: assert property (@(posedge clk) disable iff (rst)
    $onehot0(isr & ~$past(isr))); // R5
endmodule

bind pic_core pic_core_chk #(.N_IN(N_IN)) u_chk (
  .clk(clk), .rst(rst), .int_out(int_out), .vec_oe(vec_oe), .cas_oe(cas_oe),
  .inta(inta), .cfg_ready(cfg_ready), .is_slave(is_slave), .isr(isr)
);

// File: tb/pic_core_bench.sv
module pic_core_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs = 0, wr = 0, rd = 0, a0 = 0, inta = 0;
  logic [7:0] din = 0, irq_in = 0;
  logic [2:0] cas_in = 0;
  logic [7:0] dout, vec_out;
  logic [2:0] cas_out;
  logic       int_out, vec_oe, cas_oe;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pic_core u_pic_core (
    .clk(clk), .rst(rst), .cs(cs), .wr(wr), .rd(rd), .a0(a0), .din(din),
    .dout(dout), .irq_in(irq_in), .int_out(int_out), .inta(inta),
    .vec_out(vec_out), .vec_oe(vec_oe), .cas_in(cas_in), .cas_out(cas_out),
    .cas_oe(cas_oe)
  );

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic wr_reg(logic addr, logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; a0 = addr; din = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic rd_reg(logic addr, output logic [7:0] v);
    @(negedge clk); cs = 1; rd = 1; a0 = addr;
    @(negedge clk); cs = 0; rd = 0; v = dout;
  endtask

  task automatic pulse();
    @(negedge clk); inta = 1;
    @(negedge clk); inta = 0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] lowest_idx(logic [7:0] v);
    for (int i = 7; i >= 0; i--) if (v[i]) lowest_idx = 8'(i);
  endfunction

  initial begin
    logic [7:0] v, rq, mk;
    void'($urandom(32'h5eed_0042));
    wait_cyc(4);
    check("R1 int_out", {7'b0, int_out}, 8'h0);
    check("R1 vec_oe", {7'b0, vec_oe}, 8'h0);
    check("R1 cas_oe", {7'b0, cas_oe}, 8'h0);
    rst = 0;
    irq_in = 8'h01;
    wait_cyc(3);
    check("R1 no int before setup", {7'b0, int_out}, 8'h0);
    // three-word setup, base 0x56 keeps only bits 7:3
    wr_reg(0, 8'h10); wr_reg(1, 8'h56);
    wait_cyc(3);
    check("R2 int held mid-setup", {7'b0, int_out}, 8'h0);
    wr_reg(1, 8'h00);
    wait_cyc(1);
    check("R2 int after setup", {7'b0, int_out}, 8'h1);
    wr_reg(1, 8'hFF); wait_cyc(1);
    check("R3 masked", {7'b0, int_out}, 8'h0);
    rd_reg(1, v); check("R3 mask read", v, 8'hFF);
    wr_reg(1, 8'h00);
    // single request on input 2
    irq_in = 8'h04; wait_cyc(2);
    check("R4 int on input 2", {7'b0, int_out}, 8'h1);
    pulse();
    wr_reg(0, 8'h0B); rd_reg(0, v);
    check("R5 isr after first strobe", v, 8'h04);
    check("R7 isr select", v, 8'h04);
    check("R4 in-service blocks itself", {7'b0, int_out}, 8'h0);
    pulse();
    check("R5 vec_oe", {7'b0, vec_oe}, 8'h1);
    check("R5 vector", vec_out, 8'h52);
    wait_cyc(1);
    check("R5 vec_oe one cycle", {7'b0, vec_oe}, 8'h0);
    irq_in = 8'h0C; wait_cyc(2);
    check("R4 lower input blocked", {7'b0, int_out}, 8'h0);
    irq_in = 8'h0D; wait_cyc(2);
    check("R4 higher input preempts", {7'b0, int_out}, 8'h1);
    pulse(); pulse();
    check("R5 vector input 0", vec_out, 8'h50);
    rd_reg(0, v); check("R5 nested isr", v, 8'h05);
    wr_reg(0, 8'h20); rd_reg(0, v);
    check("R6 nonspecific eoi", v, 8'h04);
    wr_reg(0, 8'h62); rd_reg(0, v);
    check("R6 specific eoi", v, 8'h00);
    wr_reg(0, 8'h0A); irq_in = 8'hA0; wait_cyc(2);
    rd_reg(0, v); check("R7 irr select", v, 8'hA0);
    irq_in = 8'h00; wait_cyc(2);
    pulse(); pulse();
    check("R10 spurious vector", vec_out, 8'h57);
    wr_reg(0, 8'h0B); rd_reg(0, v);
    check("R10 isr unchanged", v, 8'h00);
    // random rounds
    for (int k = 0; k < 40; k++) begin
      rq = 8'($urandom); mk = 8'($urandom) & 8'h7F;
      wr_reg(1, mk); irq_in = rq; wait_cyc(2);
      check("R4 random int", {7'b0, int_out}, {7'b0, |(rq & ~mk)});
      if (|(rq & ~mk)) begin
        pulse(); pulse();
        check("R5 random vector", vec_out, {5'b01010, lowest_idx(rq & ~mk)[2:0]});
        wr_reg(0, 8'h20); rd_reg(0, v);
        check("R6 random eoi", v, 8'h00);
      end
      irq_in = 0; wait_cyc(2);
    end
    // restart mid-operation, then master with slave on input 3
    wr_reg(1, 8'h0F); irq_in = 8'h02; wait_cyc(2); pulse();
    wr_reg(0, 8'h11); wait_cyc(2);
    check("R11 int held after restart", {7'b0, int_out}, 8'h0);
    wr_reg(1, 8'h80); wr_reg(1, 8'h08); wr_reg(1, 8'h04);
    rd_reg(1, v); check("R11 mask cleared", v, 8'h00);
    rd_reg(0, v); check("R7 irr after restart", v, 8'h02);
    wr_reg(0, 8'h0B); rd_reg(0, v);
    check("R11 isr cleared", v, 8'h00);
    irq_in = 8'h08; wait_cyc(2);
    pulse();
    check("R8 cas_oe", {7'b0, cas_oe}, 8'h1);
    check("R8 cas_out", {5'b0, cas_out}, 8'h03);
    pulse();
    check("R8 no vector for slave input", {7'b0, vec_oe}, 8'h0);
    check("R8 cas released", {7'b0, cas_oe}, 8'h0);
    rd_reg(0, v); check("R8 master isr", v, 8'h08);
    wr_reg(0, 8'h20);
    irq_in = 8'h02; wait_cyc(2);
    pulse();
    check("R8 no cas for direct input", {7'b0, cas_oe}, 8'h0);
    pulse();
    check("R8 direct vector", vec_out, 8'h81);
    // slave with ID 5
    irq_in = 0;
    wr_reg(0, 8'h11); wr_reg(1, 8'h40); wr_reg(1, 8'h05); wr_reg(1, 8'h00);
    irq_in = 8'h10; wait_cyc(2);
    check("R9 slave int", {7'b0, int_out}, 8'h1);
    cas_in = 3'd2;
    pulse(); pulse();
    check("R9 id mismatch no vector", {7'b0, vec_oe}, 8'h0);
    wr_reg(0, 8'h0B); rd_reg(0, v);
    check("R9 id mismatch isr", v, 8'h00);
    cas_in = 3'd5;
    pulse(); pulse();
    check("R9 id match vec_oe", {7'b0, vec_oe}, 8'h1);
    check("R9 slave vector", vec_out, 8'h44);
    rd_reg(0, v); check("R9 slave isr", v, 8'h10);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog R1 got hang exp finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule